// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Generator

This block is the bus-master half of a prioritized interrupt acknowledge. Seven active-low request lines pass through a two-stage synchronizer. The highest pending level is then compared against a programmable mask level. Once a request is accepted, and only when the processor reports that an instruction has finished, the block runs a special one-byte read cycle in CPU address space. The fixed address pattern and function code of that cycle tell every device on the bus which level is being acknowledged.

The cycle first pulses a bus-clear output for one clock. It then presents the address and control lines with the strobes still high for one clock. After that it drops the address, data and output-enable strobes together. It holds them low until the responder terminates the cycle. The responder ends the cycle in one of two ways. A data-acknowledge termination latches the vector from the lowest byte lane of the data port. An autovector termination supplies a vector computed from the level and ignores the data bus. The captured vector is flagged by a one-clock valid pulse.

Top module: `irq_ack_seq`

## Requirements
- R1: A request line held low reaches the comparator through two flip-flop stages. With the instruction-done input high, bus-clear goes low in the third clock edge after the line falls, counted from the first edge that samples it.
- R2: The acknowledged level is the highest requesting line. It is accepted when it is greater than the mask level, and level 7 is accepted whatever the mask. A level equal to or below the mask (other than 7) starts no cycle.
- R3: A cycle starts only when the instruction-done input is high while the block is idle. While that input is low, bus-clear and the strobes stay high.
- R4: Each cycle is sequenced as follows: bus-clear low for exactly one clock, then one clock with address and control driven and the strobes high, then the address, data and output-enable strobes low together until termination.
- R5: From bus-clear through the end of the strobe phase, the function code is 4'b0111, the read/write output is 1 (read), and the size output is 2'b01 (one byte). In idle these outputs are parked at zero.
- R6: During a cycle the address carries ones in bits 31..20, 15..4 and 0. Bits 19..16 are 4'hF, and bits 3..1 are the acknowledged level. In idle the address is zero.
- R7: The acknowledge strobe iack_n[L] is low for the acknowledged level L during the address and strobe phases. Every other strobe is high, and all of them are high in idle.
- R8: Termination by the data acknowledge (dsack_n low) latches bus_data[7:0] as the vector. The strobes return high in the next clock.
- R9: Termination by the autovector input (avec_n low) sets the vector to 24 plus the level and ignores the data bus. When both terminations arrive in the same clock, the autovector wins.
- R10: The vec_valid output is high for exactly one clock, the first clock after termination, in which the strobes are already high.
- R11: The level is frozen when the cycle starts. Request changes during the cycle alter neither the address nor the acknowledge strobes. A still-pending request is served by the next cycle.
- R12: During and right after reset, all strobes and bus-clear are high, vec_valid is low, the vector is zero, and the bus outputs are parked at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 7 | Active-low interrupt requests, index 7..1 is the level |
| mask_lvl | input | 3 | Mask level; levels above it are accepted |
| insn_done | input | 1 | High when the processor is at an instruction boundary |
| dsack_n | input | 1 | Active-low data-acknowledge termination |
| avec_n | input | 1 | Active-low autovector termination |
| bus_data | input | 32 | Data port; the vector is on bits 7..0 |
| fc | output | 4 | Function code |
| addr | output | 32 | Address |
| rd_wr | output | 1 | 1 = read |
| siz | output | 2 | Transfer size, 2'b01 = one byte |
| as_n | output | 1 | Address strobe |
| ds_n | output | 1 | Data strobe |
| oe_n | output | 1 | Output enable |
| iack_n | output | 7 | Per-level acknowledge strobes, index 7..1 |
| bclr_n | output | 1 | Bus-clear request |
| vec | output | 8 | Captured vector |
| vec_valid | output | 1 | One-clock pulse marking a new vector |

## Verification
The two terminations, data acknowledge and autovector, can reach the block in the same clock of the strobe phase. The bench drives both low on one edge with a non-matching byte on the data lane. It judges the result by the vector alone: it must equal 24 plus the level, never the data byte. A second overlap checks that a higher request arriving mid-cycle leaves the address and acknowledge strobes untouched, while still being served by the cycle that follows.

// File: rtl/irq_ack_seq.sv
module irq_ack_seq #(
  parameter int AUTOVEC_BASE = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:1]  irq_n,
  input  logic [2:0]  mask_lvl,
  input  logic        insn_done,
  input  logic        dsack_n,
  input  logic        avec_n,
  input  logic [31:0] bus_data,
  output logic [3:0]  fc,
  output logic [31:0] addr,
  output logic        rd_wr,
  output logic [1:0]  siz,
  output logic        as_n,
  output logic        ds_n,
  output logic        oe_n,
  output logic [7:1]  iack_n,
  output logic        bclr_n,
  output logic [7:0]  vec,
  output logic        vec_valid
);
  typedef enum logic [2:0] {S_IDLE, S_CLR, S_ADR, S_STB, S_REL} st_t;

  st_t        st;
  logic [7:1] sync1, sync2;
  logic [2:0] pend_lvl, cur_lvl;
  logic       accept, active, strobe, term;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= ~irq_n;
      sync2 <= sync1;
    end

  always_comb begin
    pend_lvl = '0;
    for (int i = 1; i <= 7; i++)
      if (sync2[i]) pend_lvl = 3'(i);
  end

  assign accept = (pend_lvl != 3'd0) && (pend_lvl == 3'd7 || pend_lvl > mask_lvl);
  assign term   = !dsack_n || !avec_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      cur_lvl <= '0;
      vec     <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept && insn_done) begin
          st      <= S_CLR;
          cur_lvl <= pend_lvl;
        end
        S_CLR:  st <= S_ADR;
        S_ADR:  st <= S_STB;
        S_STB:  if (term) begin
          st  <= S_REL;
          vec <= !avec_n ? 8'(AUTOVEC_BASE) + {5'd0, cur_lvl} : bus_data[7:0];
        end
        default: st <= S_IDLE;
      endcase
    end

  assign active    = (st == S_CLR) || (st == S_ADR) || (st == S_STB);
  assign strobe    = (st == S_STB);
  assign fc        = active ? 4'b0111 : 4'b0000;
  assign addr      = active ? {28'hFFF_FFFF, cur_lvl, 1'b1} : 32'd0;
  assign rd_wr     = active;
  assign siz       = active ? 2'b01 : 2'b00;
  assign as_n      = !strobe;
  assign ds_n      = !strobe;
  assign oe_n      = !strobe;
  assign bclr_n    = (st != S_CLR);
  assign vec_valid = (st == S_REL);

  for (genvar g = 1; g <= 7; g++) begin : g_iack
    assign iack_n[g] = !(((st == S_ADR) || strobe) && cur_lvl == 3'(g));
  end
endmodule

// File: rtl/irq_ack_seq_chk.sv
module irq_ack_seq_chk #(
  parameter int AUTOVEC_BASE = 24
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:1]  irq_n,
  input logic [2:0]  mask_lvl,
  input logic        insn_done,
  input logic        dsack_n,
  input logic        avec_n,
  input logic [31:0] bus_data,
  input logic [3:0]  fc,
  input logic [31:0] addr,
  input logic        rd_wr,
  input logic [1:0]  siz,
  input logic        as_n,
  input logic        ds_n,
  input logic        oe_n,
  input logic [7:1]  iack_n,
  input logic        bclr_n,
  input logic [7:0]  vec,
  input logic        vec_valid
);
  AST_CPU_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> (fc == 4'b0111 && rd_wr && siz == 2'b01)); // R5
  AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> (addr[31:20] == 12'hFFF && addr[19:16] == 4'hF && addr[15:4] == 12'hFFF && addr[0])); // R6
  AST_IACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~iack_n)); // R7
  AST_IACK_IN_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> ($countones(~iack_n) == 1 && !iack_n[addr[3:1]])); // R7
  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bclr_n) |=> (bclr_n && as_n)); // R4
  AST_STB_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(as_n) |-> ($past(!bclr_n, 2) && !ds_n && !oe_n)); // R4
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bclr_n) |-> $past(insn_done)); // R3
  AST_VV_AFTER_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> ($past(!as_n) && as_n)); // R10
  AST_VV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid); // R10
  AST_AUTOVEC: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && $past(!avec_n)) |-> (vec == 8'(AUTOVEC_BASE) + {5'd0, $past(addr[3:1])})); // R9
  AST_DSACK_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && $past(avec_n)) |-> (vec == $past(bus_data[7:0]))); // R8
  AST_LVL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && $past(!as_n)) |-> ($stable(addr) && $stable(iack_n))); // R11
endmodule

bind irq_ack_seq irq_ack_seq_chk #(.AUTOVEC_BASE(AUTOVEC_BASE)) u_chk (.*);

// File: tb/tb_irq_ack_seq.sv
module tb_irq_ack_seq;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:1]  irq_n;
  logic [2:0]  mask_lvl;
  logic        insn_done;
  logic        dsack_n;
  logic        avec_n;
  logic [31:0] bus_data;
  logic [3:0]  fc;
  logic [31:0] addr;
  logic        rd_wr;
  logic [1:0]  siz;
  logic        as_n, ds_n, oe_n;
  logic [7:1]  iack_n;
  logic        bclr_n;
  logic [7:0]  vec;
  logic        vec_valid;

  int errors = 0;
  int checks = 0;

  irq_ack_seq dut (.*);

  always #(CLK_P/2) clk = ~clk;

  // {irq_n[7:1], mask, term(0 dsack,1 avec,2 both), data, take, lvl, vec}
  localparam logic [31:0] TBL [8] = '{
    {7'b111_1011, 3'd0, 2'd0, 8'hA5, 1'b1, 3'd3, 8'hA5},
    {7'b110_1101, 3'd1, 2'd1, 8'h33, 1'b1, 3'd5, 8'h1D},
    {7'b111_0111, 3'd4, 2'd0, 8'h77, 1'b0, 3'd0, 8'h00},
    {7'b011_1111, 3'd7, 2'd0, 8'h5C, 1'b1, 3'd7, 8'h5C},
    {7'b101_1111, 3'd7, 2'd0, 8'h66, 1'b0, 3'd0, 8'h00},
    {7'b111_1110, 3'd0, 2'd2, 8'hEE, 1'b1, 3'd1, 8'h19},
    {7'b000_0000, 3'd3, 2'd0, 8'h80, 1'b1, 3'd7, 8'h80},
    {7'b111_1101, 3'd1, 2'd0, 8'h00, 1'b1, 3'd2, 8'h00}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wait_strobe(output int n_clr, output int n_as);
    n_clr = 0;
    n_as  = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (!bclr_n && n_clr == 0) n_clr = k;
      if (!as_n) begin
        n_as = k;
        break;
      end
    end
  endtask

  task automatic terminate(input logic [1:0] t, input logic [7:0] d);
    dsack_n  = !(t == 2'd0 || t == 2'd2);
    avec_n   = !(t == 2'd1 || t == 2'd2);
    bus_data = {24'hDEAD_BE, d};
    @(negedge clk);
    dsack_n = 1'b1;
    avec_n  = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int n_clr, n_as;
    rst_n = 1'b0; irq_n = '1; mask_lvl = '0; insn_done = 1'b0;
    dsack_n = 1'b1; avec_n = 1'b1; bus_data = '0;
    repeat (3) @(negedge clk);
    check(as_n && ds_n && oe_n && bclr_n && iack_n == 7'h7F && !vec_valid && vec == 8'd0 && addr == 32'd0 && fc == 4'd0,
          "R12 reset", {iack_n, as_n, bclr_n}, 9'h1FF);
    rst_n = 1'b1;
    @(negedge clk);
    check(as_n && bclr_n && !vec_valid && vec == 8'd0 && rd_wr == 1'b0 && siz == 2'd0, "R12 after reset",
          {as_n, bclr_n, vec_valid}, 3'b110);

    foreach (TBL[i]) begin
      logic [31:0] e;
      e = TBL[i];
      irq_n = e[31:25]; mask_lvl = e[24:22]; insn_done = 1'b1;
      wait_strobe(n_clr, n_as);
      if (e[11]) begin
        check(n_clr == 3, "R1 bclr latency", n_clr, 3);
        check(n_as == 5, "R4 strobe latency", n_as, 5);
        check(!ds_n && !oe_n, "R4 strobes together", {ds_n, oe_n}, 0);
        check(fc == 4'b0111 && rd_wr && siz == 2'b01, "R5 cpu space", {fc, rd_wr, siz}, 7'b0111101);
        check(addr == {28'hFFF_FFFF, e[10:8], 1'b1}, "R6 R2 address", addr, {28'hFFF_FFFF, e[10:8], 1'b1});
        check(iack_n == ~(7'd1 << (e[10:8] - 3'd1)), "R7 iack", iack_n, ~(7'd1 << (e[10:8] - 3'd1)));
        terminate(e[21:20], e[19:12]);
        check(vec_valid && as_n && ds_n && oe_n, "R10 valid with strobes high", {vec_valid, as_n}, 2'b11);
        check(vec == e[7:0], e[21:20] == 2'd0 ? "R8 dsack vector" : "R9 autovector", vec, e[7:0]);
        irq_n = '1; insn_done = 1'b0;
        @(negedge clk);
        check(!vec_valid, "R10 single pulse", vec_valid, 0);
      end else begin
        check(n_clr == 0 && n_as == 0, "R2 masked request", {n_clr[7:0], n_as[7:0]}, 0);
        irq_n = '1; insn_done = 1'b0;
      end
      repeat (4) @(negedge clk);
    end

    // R3: hold off until the instruction boundary
    irq_n = 7'b111_0111; mask_lvl = 3'd0; insn_done = 1'b0;
    begin
      bit quiet = 1'b1;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (!bclr_n || !as_n) quiet = 1'b0;
      end
      check(quiet, "R3 no start while busy", quiet, 1);
    end
    insn_done = 1'b1;
    wait_strobe(n_clr, n_as);
    check(n_clr == 1 && n_as == 3, "R3 start at boundary", {n_clr[7:0], n_as[7:0]}, 16'h0103);
    terminate(2'd0, 8'h3C);
    check(vec == 8'h3C && vec_valid, "R8 vector after hold", vec, 8'h3C);
    irq_n = '1; insn_done = 1'b0;
    repeat (4) @(negedge clk);

    // R11: higher request during a cycle
    irq_n = 7'b111_1011; insn_done = 1'b1;
    wait_strobe(n_clr, n_as);
    irq_n[7] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!as_n && addr[3:1] == 3'd3 && iack_n == 7'b111_1011, "R11 level frozen", {addr[3:1], iack_n}, {3'd3, 7'b111_1011});
    end
    terminate(2'd2, 8'h42);
    check(vec == 8'h1B, "R9 both terminations autovector", vec, 8'h1B);
    irq_n[3] = 1'b1;
    wait_strobe(n_clr, n_as);
    check(n_as != 0 && addr[3:1] == 3'd7 && !iack_n[7], "R11 pending served next", {n_as[7:0], addr[3:1]}, {8'd4, 3'd7});
    terminate(2'd1, 8'h99);
    check(vec == 8'h1F, "R9 level 7 autovector", vec, 8'h1F);
    irq_n = '1; insn_done = 1'b0;
    repeat (4) @(negedge clk);
    report();
  end
endmodule